// File: doc/BRIEF.md
# Instruction Class Decoder

This block sorts a 32-bit fixed-width instruction word into one of fifteen classes and pulls out everything a later pipeline stage needs to act on it. That includes the condition nibble, the four register selectors, the ALU opcode and the flag-update bit. It also provides a fully expanded second operand: the rotated 8-bit immediate, or the shift kind and amount for a register operand. For some classes it adds extra fields: the split 8-bit offset of halfword transfers, multiply, exchange and swap variants, the addressing order of block transfers, the coprocessor move direction, and the absolute target of a relative branch.

Several special encodings share the opcode space of the generic data-processing class. They are found by mask-and-compare against fixed patterns, and a fixed priority picks among them before the data-processing class is allowed. Encodings that fit no class raise an undefined flag, and the class vector is then all zero. All outputs are registered when `REG_OUT` is set (the default), which gives one cycle of latency. Condition evaluation and execution are not part of this block.

Top module: `insn_class_decoder`

## Requirements
- R1: `cls_o` is one-hot or all zero, and exactly one of "one class bit set" and `undef_o` holds. Class bit indices are: 0 multiply, 1 long multiply, 2 branch-exchange, 3 status write, 4 status read, 5 swap, 6 halfword/signed transfer, 7 data processing, 8 single transfer, 9 block transfer, 10 branch, 11 coprocessor transfer, 12 coprocessor data op, 13 coprocessor register move, 14 software interrupt.
- R2: Multiply is `(w & 0x0FC000F0) == 0x00000090` and long multiply is `(w & 0x0F8000F0) == 0x00800090`. For long multiply, `mul_signed_o` is bit 22 and `mul_acc_o` is bit 21; for short multiply, `mul_acc_o` is bit 21. Both matches win over the halfword match.
- R3: Branch-exchange is `(w & 0x0FF000D0) == 0x01200010`, with `bx_link_o` taken from bit 5. Swap is `(w & 0x0FB00FF0) == 0x01000090`, with `swap_byte_o` taken from bit 22. Swap wins over halfword.
- R4: Status write matches `(w & 0x0FB0FFF0) == 0x0120F000` or `(w & 0x0FB0F000) == 0x0320F000`. Status read matches `(w & 0x0FBF0FFF) == 0x010F0000`.
- R5: Halfword/signed transfer is `(w & 0x0E000090) == 0x00000090` when no earlier special matches. `xfer_imm8_o` is `{w[11:8], w[3:0]}`. A store (bit 20 = 0) with bits 7, 6 and 4 all set and an odd Rd is undefined.
- R6: Any other word with bits 27:26 = 00 is data processing. `alu_op_o` = bits 24:21, `set_flags_o` = bit 20, `cond_o` = bits 31:28, `rn_o` = 19:16, `rd_o` = 15:12, `rs_o` = 11:8, `rm_o` = 3:0.
- R7: `op2_imm_o` is always bits 7:0 rotated right by twice bits 11:8. `op2_imm_sel_o` is bit 25 for the data-processing and status-write classes, and 0 for every other class.
- R8: Shift fields come from bits 11:4. `shift_kind_o` encodes 0 shift left, 1 logical right, 2 arithmetic right, 3 rotate right, 4 rotate-through-carry by one. With bit 4 set the amount comes from a register: `shift_reg_o` = 1, the kind is bits 6:5 and `shift_amt_o` = 0. Otherwise the amount is bits 11:7; an amount of 0 means 32 for the two right shifts, and turns rotate right into kind 4 with amount 1.
- R9: Main opcodes 4 to 7 (bits 27:24) are single transfers, except that opcodes 6 and 7 with bit 4 set are undefined.
- R10: Main opcodes 8 and 9 are block transfers. `blk_order_o` = {bit 24, bit 23}, meaning 0 decrement-after, 1 increment-after, 2 decrement-before, 3 increment-before. `blk_user_o` is bit 22.
- R11: Main opcodes 0xA and 0xB are branches. `br_link_o` is bit 24, and `br_target_o` = `pc_i` + 8 + sign-extended (bits 23:0 shifted left by 2), modulo 2^PC_W.
- R12: Main opcodes 0xC and 0xD are coprocessor transfers. 0xE with bit 4 set is a register move, with `cp_read_o` = bit 20. 0xE with bit 4 clear is a coprocessor data op. 0xF is a software interrupt.
- R13: With `REG_OUT` = 1, every output shows the decode of the word present at the previous rising edge. Synchronous reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction word |
| pc_i | input | PC_W | Address of the instruction |
| cls_o | output | 15 | One-hot class |
| undef_o | output | 1 | No class matched |
| cond_o | output | 4 | Condition nibble |
| rn_o | output | 4 | First operand register |
| rd_o | output | 4 | Destination register |
| rs_o | output | 4 | Shift/multiply register |
| rm_o | output | 4 | Second operand register |
| alu_op_o | output | 4 | Data-processing opcode |
| set_flags_o | output | 1 | Flag update / load bit |
| op2_imm_sel_o | output | 1 | Second operand is the rotated immediate |
| op2_imm_o | output | 32 | Expanded rotated immediate |
| shift_kind_o | output | 3 | Shift kind code |
| shift_reg_o | output | 1 | Shift amount taken from a register |
| shift_amt_o | output | 6 | Immediate shift amount |
| xfer_imm8_o | output | 8 | Halfword transfer offset |
| mul_signed_o | output | 1 | Signed long multiply |
| mul_acc_o | output | 1 | Multiply with accumulate |
| bx_link_o | output | 1 | Branch-exchange with link |
| swap_byte_o | output | 1 | Byte swap |
| cp_read_o | output | 1 | Coprocessor move reads from the coprocessor |
| blk_order_o | output | 2 | Block transfer addressing order |
| blk_user_o | output | 1 | Block transfer user-bank flag |
| br_link_o | output | 1 | Branch with link |
| br_target_o | output | PC_W | Branch target address |

## Verification
A mask-matched special encoding and the generic halfword or data-processing decode can both claim the same word in the same cycle. A multiply or swap word also satisfies the halfword mask, and a status-write word also falls in the data-processing opcode space. The bench applies exactly such overlapping words and expects only the higher-priority class bit to be set, together with the variant fields of that class. It also checks that a store-double word with an odd Rd, which satisfies the halfword mask, comes out undefined rather than as any class.

// File: rtl/icd_pkg.sv
package icd_pkg;

  localparam int INSN_W   = 32;
  localparam int NCLS     = 15;
  localparam int NSPEC    = 8;
  localparam int NSPECCLS = 7;

  localparam int C_MUL    = 0;
  localparam int C_MULL   = 1;
  localparam int C_BX     = 2;
  localparam int C_SWR    = 3;
  localparam int C_SRD    = 4;
  localparam int C_SWP    = 5;
  localparam int C_HALF   = 6;
  localparam int C_DP     = 7;
  localparam int C_SINGLE = 8;
  localparam int C_BLOCK  = 9;
  localparam int C_BRANCH = 10;
  localparam int C_CPX    = 11;
  localparam int C_CPD    = 12;
  localparam int C_CPMOV  = 13;
  localparam int C_SWI    = 14;

  // Special encodings in priority order; two patterns share the status-write class.
  localparam logic [27:0] SPEC_MASK [NSPEC] = '{
    28'hFC000F0, 28'hF8000F0, 28'hFF000D0, 28'hFB0FFF0,
    28'hFB0F000, 28'hFBF0FFF, 28'hFB00FF0, 28'hE000090
  };
  localparam logic [27:0] SPEC_PAT [NSPEC] = '{
    28'h0000090, 28'h0800090, 28'h1200010, 28'h120F000,
    28'h320F000, 28'h10F0000, 28'h1000090, 28'h0000090
  };
  localparam int SPEC_CLS [NSPEC] = '{
    C_MUL, C_MULL, C_BX, C_SWR, C_SWR, C_SRD, C_SWP, C_HALF
  };

  typedef enum logic [2:0] {
    SH_LSL = 3'd0,
    SH_LSR = 3'd1,
    SH_ASR = 3'd2,
    SH_ROR = 3'd3,
    SH_RRX = 3'd4
  } shkind_e;

  typedef struct packed {
    logic [NCLS-1:0]   cls;
    logic              undef;
    logic [3:0]        cond;
    logic [3:0]        rn;
    logic [3:0]        rd;
    logic [3:0]        rs;
    logic [3:0]        rm;
    logic [3:0]        alu_op;
    logic              set_flags;
    logic              op2_imm_sel;
    logic [INSN_W-1:0] op2_imm;
    logic [2:0]        shift_kind;
    logic              shift_reg;
    logic [5:0]        shift_amt;
    logic [7:0]        xfer_imm8;
    logic              mul_signed;
    logic              mul_acc;
    logic              bx_link;
    logic              swap_byte;
    logic              cp_read;
    logic [1:0]        blk_order;
    logic              blk_user;
    logic              br_link;
  } dec_t;

endpackage

// File: rtl/icd_special_match.sv
module icd_special_match
  import icd_pkg::*;
(
  input  logic [27:0]         body_i,
  output logic [NSPECCLS-1:0] hit_o
);

  logic [NSPEC-1:0] raw;

  generate
    for (genvar k = 0; k < NSPEC; k++) begin : g_pat
      assign raw[k] = ((body_i & SPEC_MASK[k]) == SPEC_PAT[k]);
    end
  endgenerate

  always_comb begin
    hit_o = '0;
    for (int k = 0; k < NSPEC; k++) begin
      if (raw[k]) hit_o[SPEC_CLS[k]] = 1'b1;
    end
  end

endmodule

// File: rtl/icd_class_select.sv
module icd_class_select
  import icd_pkg::*;
(
  input  logic [3:0]          main_i,
  input  logic                b20_i,
  input  logic                b12_i,
  input  logic                b7_i,
  input  logic                b6_i,
  input  logic                b4_i,
  input  logic [NSPECCLS-1:0] spec_hit_i,
  output logic [NCLS-1:0]     cls_o,
  output logic                undef_o
);

  logic [NSPECCLS-1:0] spec_win;
  logic                dbl_odd;

  // Lowest class index among the special hits wins.
  always_comb begin
    spec_win = '0;
    for (int c = NSPECCLS - 1; c >= 0; c--) begin
      if (spec_hit_i[c]) spec_win = NSPECCLS'(1) << c;
    end
  end

  assign dbl_odd = !b20_i && b7_i && b6_i && b4_i && b12_i;

  always_comb begin
    cls_o   = '0;
    undef_o = 1'b0;
    case (main_i)
      4'h0, 4'h1, 4'h2, 4'h3: begin
        if (spec_win == '0) begin
          cls_o[C_DP] = 1'b1;
        end else if (spec_win[C_HALF] && dbl_odd) begin
          undef_o = 1'b1;
        end else begin
          cls_o[NSPECCLS-1:0] = spec_win;
        end
      end
      4'h4, 4'h5: cls_o[C_SINGLE] = 1'b1;
      4'h6, 4'h7: begin
        if (b4_i) undef_o = 1'b1;
        else      cls_o[C_SINGLE] = 1'b1;
      end
      4'h8, 4'h9: cls_o[C_BLOCK]  = 1'b1;
      4'hA, 4'hB: cls_o[C_BRANCH] = 1'b1;
      4'hC, 4'hD: cls_o[C_CPX]    = 1'b1;
      4'hE: begin
        if (b4_i) cls_o[C_CPMOV] = 1'b1;
        else      cls_o[C_CPD]   = 1'b1;
      end
      default:    cls_o[C_SWI]    = 1'b1;
    endcase
  end

endmodule

// File: rtl/icd_operand_expand.sv
module icd_operand_expand
  import icd_pkg::*;
(
  input  logic [11:0]       low_i,
  output logic [INSN_W-1:0] imm_o,
  output logic [2:0]        kind_o,
  output logic              by_reg_o,
  output logic [5:0]        amt_o,
  output logic [7:0]        imm8_o
);

  localparam int RW = $clog2(INSN_W) + 1;

  logic [INSN_W-1:0] base;
  logic [RW-1:0]     rot;
  logic [4:0]        sh_imm;

  assign base  = INSN_W'(low_i[7:0]);
  assign rot   = RW'({low_i[11:8], 1'b0});
  assign imm_o = (base >> rot) | (base << (RW'(INSN_W) - rot));

  assign imm8_o = {low_i[11:8], low_i[3:0]};
  assign sh_imm = low_i[11:7];

  always_comb begin
    by_reg_o = low_i[4];
    kind_o   = {1'b0, low_i[6:5]};
    amt_o    = 6'(sh_imm);
    if (low_i[4]) begin
      amt_o = '0;
    end else if (sh_imm == '0) begin
      case (low_i[6:5])
        2'd1, 2'd2: amt_o = 6'd32;
        2'd3: begin
          kind_o = SH_RRX;
          amt_o  = 6'd1;
        end
        default: amt_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/icd_branch_target.sv
module icd_branch_target #(
  parameter int PC_W = 32
) (
  input  logic [23:0]     off_i,
  input  logic [PC_W-1:0] pc_i,
  output logic [PC_W-1:0] tgt_o
);

  localparam int OFF_W = 26;
  localparam int EXT_W = PC_W - OFF_W;

  logic [OFF_W-1:0] off_sh;
  logic [PC_W-1:0]  off_ext;

  assign off_sh  = {off_i, 2'b00};
  assign off_ext = {{EXT_W{off_sh[OFF_W-1]}}, off_sh};
  assign tgt_o   = pc_i + PC_W'(8) + off_ext;

endmodule

// File: rtl/insn_class_decoder.sv
module insn_class_decoder
  import icd_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       instr_i,
  input  logic [PC_W-1:0]   pc_i,
  output logic [14:0]       cls_o,
  output logic              undef_o,
  output logic [3:0]        cond_o,
  output logic [3:0]        rn_o,
  output logic [3:0]        rd_o,
  output logic [3:0]        rs_o,
  output logic [3:0]        rm_o,
  output logic [3:0]        alu_op_o,
  output logic              set_flags_o,
  output logic              op2_imm_sel_o,
  output logic [31:0]       op2_imm_o,
  output logic [2:0]        shift_kind_o,
  output logic              shift_reg_o,
  output logic [5:0]        shift_amt_o,
  output logic [7:0]        xfer_imm8_o,
  output logic              mul_signed_o,
  output logic              mul_acc_o,
  output logic              bx_link_o,
  output logic              swap_byte_o,
  output logic              cp_read_o,
  output logic [1:0]        blk_order_o,
  output logic              blk_user_o,
  output logic              br_link_o,
  output logic [PC_W-1:0]   br_target_o
);

  logic [NSPECCLS-1:0] spec_hit;
  logic [NCLS-1:0]     cls;
  logic                undef;
  logic [INSN_W-1:0]   imm;
  logic [2:0]          kind;
  logic                by_reg;
  logic [5:0]          amt;
  logic [7:0]          imm8;
  logic [PC_W-1:0]     tgt;
  dec_t                d, q;
  logic [PC_W-1:0]     tgt_q;

  icd_special_match u_spec (
    .body_i (instr_i[27:0]),
    .hit_o  (spec_hit)
  );

  icd_class_select u_sel (
    .main_i     (instr_i[27:24]),
    .b20_i      (instr_i[20]),
    .b12_i      (instr_i[12]),
    .b7_i       (instr_i[7]),
    .b6_i       (instr_i[6]),
    .b4_i       (instr_i[4]),
    .spec_hit_i (spec_hit),
    .cls_o      (cls),
    .undef_o    (undef)
  );

  icd_operand_expand u_op2 (
    .low_i    (instr_i[11:0]),
    .imm_o    (imm),
    .kind_o   (kind),
    .by_reg_o (by_reg),
    .amt_o    (amt),
    .imm8_o   (imm8)
  );

  icd_branch_target #(.PC_W(PC_W)) u_br (
    .off_i (instr_i[23:0]),
    .pc_i  (pc_i),
    .tgt_o (tgt)
  );

  always_comb begin
    d             = '0;
    d.cls         = cls;
    d.undef       = undef;
    d.cond        = instr_i[31:28];
    d.rn          = instr_i[19:16];
    d.rd          = instr_i[15:12];
    d.rs          = instr_i[11:8];
    d.rm          = instr_i[3:0];
    d.alu_op      = instr_i[24:21];
    d.set_flags   = instr_i[20];
    d.op2_imm_sel = instr_i[25] && (cls[C_DP] || cls[C_SWR]);
    d.op2_imm     = imm;
    d.shift_kind  = kind;
    d.shift_reg   = by_reg;
    d.shift_amt   = amt;
    d.xfer_imm8   = imm8;
    d.mul_signed  = cls[C_MULL] && instr_i[22];
    d.mul_acc     = (cls[C_MULL] || cls[C_MUL]) && instr_i[21];
    d.bx_link     = cls[C_BX] && instr_i[5];
    d.swap_byte   = cls[C_SWP] && instr_i[22];
    d.cp_read     = cls[C_CPMOV] && instr_i[20];
    d.blk_order   = cls[C_BLOCK] ? instr_i[24:23] : 2'b00;
    d.blk_user    = cls[C_BLOCK] && instr_i[22];
    d.br_link     = cls[C_BRANCH] && instr_i[24];
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          q     <= '0;
          tgt_q <= '0;
        end else begin
          q     <= d;
          tgt_q <= tgt;
        end
      end
    end else begin : g_comb
      assign q     = d;
      assign tgt_q = tgt;
    end
  endgenerate

  assign cls_o         = q.cls;
  assign undef_o       = q.undef;
  assign cond_o        = q.cond;
  assign rn_o          = q.rn;
  assign rd_o          = q.rd;
  assign rs_o          = q.rs;
  assign rm_o          = q.rm;
  assign alu_op_o      = q.alu_op;
  assign set_flags_o   = q.set_flags;
  assign op2_imm_sel_o = q.op2_imm_sel;
  assign op2_imm_o     = q.op2_imm;
  assign shift_kind_o  = q.shift_kind;
  assign shift_reg_o   = q.shift_reg;
  assign shift_amt_o   = q.shift_amt;
  assign xfer_imm8_o   = q.xfer_imm8;
  assign mul_signed_o  = q.mul_signed;
  assign mul_acc_o     = q.mul_acc;
  assign bx_link_o     = q.bx_link;
  assign swap_byte_o   = q.swap_byte;
  assign cp_read_o     = q.cp_read;
  assign blk_order_o   = q.blk_order;
  assign blk_user_o    = q.blk_user;
  assign br_link_o     = q.br_link;
  assign br_target_o   = tgt_q;

endmodule

// File: rtl/insn_class_decoder_chk.sv
module insn_class_decoder_chk #(
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk,
  input logic        rst,
  input logic [31:0] instr_i,
  input logic [14:0] cls_o,
  input logic        undef_o,
  input logic [31:0] op2_imm_o,
  input logic [2:0]  shift_kind_o,
  input logic        shift_reg_o,
  input logic [5:0]  shift_amt_o,
  input logic        cp_read_o
);

  logic [31:0] src_q;
  logic        primed_q;
  logic [31:0] src;
  logic        primed;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q    <= '0;
      primed_q <= 1'b0;
    end else begin
      src_q    <= instr_i;
      primed_q <= 1'b1;
    end
  end

  assign src    = REG_OUT ? src_q : instr_i;
  assign primed = REG_OUT ? primed_q : 1'b1;

  // R1
  a_r1_class_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cls_o));

  // R1
  a_r1_undef_exclusive: assert property (@(posedge clk) disable iff (rst)
    primed |-> (undef_o != ($countones(cls_o) == 1)));

  // R2
  a_r2_mul_beats_half: assert property (@(posedge clk) disable iff (rst)
    (primed && ((src & 32'h0FC000F0) == 32'h00000090)) |-> cls_o[0]);

  // R7
  a_r7_rot_popcount: assert property (@(posedge clk) disable iff (rst)
    primed |-> ($countones(op2_imm_o) == $countones(src[7:0])));

  // R8
  a_r8_rrx_form: assert property (@(posedge clk) disable iff (rst)
    (primed && shift_kind_o == 3'd4) |-> (shift_amt_o == 6'd1 && !shift_reg_o));

  // R12
  a_r12_cp_move_dir: assert property (@(posedge clk) disable iff (rst)
    (primed && cls_o[13]) |-> (src[4] && cp_read_o == src[20]));

  // R13
  a_r13_reset_clear: assert property (@(posedge clk) disable iff (rst)
    (REG_OUT && !primed_q) |-> (cls_o == '0 && !undef_o));

endmodule

bind insn_class_decoder insn_class_decoder_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .instr_i      (instr_i),
  .cls_o        (cls_o),
  .undef_o      (undef_o),
  .op2_imm_o    (op2_imm_o),
  .shift_kind_o (shift_kind_o),
  .shift_reg_o  (shift_reg_o),
  .shift_amt_o  (shift_amt_o),
  .cp_read_o    (cp_read_o)
);

// File: tb/insn_class_decoder_bench.sv
`timescale 1ns/1ps
module insn_class_decoder_bench;

  localparam int PC_W = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [31:0]     instr_i = '0;
  logic [PC_W-1:0] pc_i = '0;
  logic [14:0]     cls_o;
  logic            undef_o;
  logic [3:0]      cond_o, rn_o, rd_o, rs_o, rm_o, alu_op_o;
  logic            set_flags_o, op2_imm_sel_o;
  logic [31:0]     op2_imm_o;
  logic [2:0]      shift_kind_o;
  logic            shift_reg_o;
  logic [5:0]      shift_amt_o;
  logic [7:0]      xfer_imm8_o;
  logic            mul_signed_o, mul_acc_o, bx_link_o, swap_byte_o, cp_read_o;
  logic [1:0]      blk_order_o;
  logic            blk_user_o, br_link_o;
  logic [PC_W-1:0] br_target_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  insn_class_decoder #(.PC_W(PC_W), .REG_OUT(1'b1)) u_insn_class_decoder (
    .clk(clk), .rst(rst), .instr_i(instr_i), .pc_i(pc_i),
    .cls_o(cls_o), .undef_o(undef_o), .cond_o(cond_o), .rn_o(rn_o),
    .rd_o(rd_o), .rs_o(rs_o), .rm_o(rm_o), .alu_op_o(alu_op_o),
    .set_flags_o(set_flags_o), .op2_imm_sel_o(op2_imm_sel_o),
    .op2_imm_o(op2_imm_o), .shift_kind_o(shift_kind_o),
    .shift_reg_o(shift_reg_o), .shift_amt_o(shift_amt_o),
    .xfer_imm8_o(xfer_imm8_o), .mul_signed_o(mul_signed_o),
    .mul_acc_o(mul_acc_o), .bx_link_o(bx_link_o), .swap_byte_o(swap_byte_o),
    .cp_read_o(cp_read_o), .blk_order_o(blk_order_o), .blk_user_o(blk_user_o),
    .br_link_o(br_link_o), .br_target_o(br_target_o)
  );

  function automatic logic [14:0] oh(input int idx);
    return 15'(1) << idx;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Drive at a falling edge; result is registered at the next rising edge
  // and sampled at the falling edge after it.
  task automatic apply(input logic [31:0] w, input logic [PC_W-1:0] p);
    @(negedge clk);
    instr_i = w;
    pc_i    = p;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R13", "cls after reset", 64'(cls_o), 64'h0);
    chk("R13", "undef after reset", 64'(undef_o), 64'h0);
    chk("R13", "imm after reset", 64'(op2_imm_o), 64'h0);
    chk("R13", "target after reset", 64'(br_target_o), 64'h0);
  endtask

  task automatic t_multiply();
    apply(32'hE0230291, '0);
    chk("R2", "mul class", 64'(cls_o), 64'(oh(0)));
    chk("R2", "mul acc", 64'(mul_acc_o), 64'h1);
    chk("R6", "mul rn", 64'(rn_o), 64'h3);
    chk("R6", "mul rs", 64'(rs_o), 64'h2);
    chk("R6", "mul rm", 64'(rm_o), 64'h1);
    apply(32'hE0E54392, '0);
    chk("R2", "long mul class", 64'(cls_o), 64'(oh(1)));
    chk("R2", "long mul signed", 64'(mul_signed_o), 64'h1);
    chk("R2", "long mul acc", 64'(mul_acc_o), 64'h1);
    apply(32'hE0854392, '0);
    chk("R2", "unsigned long mul signed", 64'(mul_signed_o), 64'h0);
  endtask

  task automatic t_bx_swap();
    apply(32'hE12FFF33, '0);
    chk("R3", "bx class", 64'(cls_o), 64'(oh(2)));
    chk("R3", "bx link", 64'(bx_link_o), 64'h1);
    chk("R6", "bx rm", 64'(rm_o), 64'h3);
    apply(32'hE12FFF13, '0);
    chk("R3", "bx no link", 64'(bx_link_o), 64'h0);
    apply(32'hE1432091, '0);
    chk("R3", "swap class", 64'(cls_o), 64'(oh(5)));
    chk("R3", "swap byte", 64'(swap_byte_o), 64'h1);
  endtask

  task automatic t_status();
    apply(32'hE129F001, '0);
    chk("R4", "status write reg", 64'(cls_o), 64'(oh(3)));
    chk("R7", "status write reg imm sel", 64'(op2_imm_sel_o), 64'h0);
    apply(32'hE328F4FF, '0);
    chk("R4", "status write imm", 64'(cls_o), 64'(oh(3)));
    chk("R7", "status write imm sel", 64'(op2_imm_sel_o), 64'h1);
    chk("R7", "status write imm value", 64'(op2_imm_o), 64'hFF000000);
    apply(32'hE10F1000, '0);
    chk("R4", "status read", 64'(cls_o), 64'(oh(4)));
    chk("R6", "status read rd", 64'(rd_o), 64'h1);
  endtask

  task automatic t_halfword();
    apply(32'hE1D32AB4, '0);
    chk("R5", "half class", 64'(cls_o), 64'(oh(6)));
    chk("R5", "half imm8", 64'(xfer_imm8_o), 64'hA4);
    apply(32'hE1C310F0, '0);
    chk("R5", "store double odd rd undef", 64'(undef_o), 64'h1);
    chk("R5", "store double odd rd cls", 64'(cls_o), 64'h0);
    apply(32'hE1C320F0, '0);
    chk("R5", "store double even rd", 64'(cls_o), 64'(oh(6)));
  endtask

  task automatic t_dataproc();
    apply(32'hE3A01C3F, '0);
    chk("R6", "dp class", 64'(cls_o), 64'(oh(7)));
    chk("R6", "dp opcode", 64'(alu_op_o), 64'hD);
    chk("R6", "dp set", 64'(set_flags_o), 64'h0);
    chk("R6", "dp cond", 64'(cond_o), 64'hE);
    chk("R7", "imm rot 24", 64'(op2_imm_o), 64'h00003F00);
    chk("R7", "imm sel", 64'(op2_imm_sel_o), 64'h1);
    apply(32'h129121FF, '0);
    chk("R7", "imm rot 2 wraps", 64'(op2_imm_o), 64'hC000003F);
    chk("R6", "dp opcode 4", 64'(alu_op_o), 64'h4);
    chk("R6", "dp set 1", 64'(set_flags_o), 64'h1);
    chk("R6", "dp cond 1", 64'(cond_o), 64'h1);
    chk("R6", "dp rn", 64'(rn_o), 64'h1);
    chk("R6", "dp rd", 64'(rd_o), 64'h2);
  endtask

  task automatic t_shifts();
    apply(32'hE1A00001, '0);
    chk("R8", "lsl 0 kind", 64'(shift_kind_o), 64'h0);
    chk("R8", "lsl 0 amt", 64'(shift_amt_o), 64'h0);
    chk("R7", "reg form imm sel", 64'(op2_imm_sel_o), 64'h0);
    apply(32'hE1A00021, '0);
    chk("R8", "lsr 0 kind", 64'(shift_kind_o), 64'h1);
    chk("R8", "lsr 0 means 32", 64'(shift_amt_o), 64'd32);
    apply(32'hE1A00041, '0);
    chk("R8", "asr 0 means 32", 64'(shift_amt_o), 64'd32);
    chk("R8", "asr kind", 64'(shift_kind_o), 64'h2);
    apply(32'hE1A00061, '0);
    chk("R8", "ror 0 is rrx", 64'(shift_kind_o), 64'h4);
    chk("R8", "rrx amt", 64'(shift_amt_o), 64'h1);
    apply(32'hE1A001E1, '0);
    chk("R8", "ror 3 kind", 64'(shift_kind_o), 64'h3);
    chk("R8", "ror 3 amt", 64'(shift_amt_o), 64'h3);
    apply(32'hE1A01312, '0);
    chk("R8", "reg shift flag", 64'(shift_reg_o), 64'h1);
    chk("R8", "reg shift amt", 64'(shift_amt_o), 64'h0);
    chk("R8", "reg shift rs", 64'(rs_o), 64'h3);
    chk("R6", "reg shift class", 64'(cls_o), 64'(oh(7)));
  endtask

  task automatic t_single();
    apply(32'hE5912004, '0);
    chk("R9", "single imm class", 64'(cls_o), 64'(oh(8)));
    apply(32'hE7912003, '0);
    chk("R9", "single reg class", 64'(cls_o), 64'(oh(8)));
    apply(32'hE7912013, '0);
    chk("R9", "single reg bit4 undef", 64'(undef_o), 64'h1);
    chk("R9", "single reg bit4 cls", 64'(cls_o), 64'h0);
  endtask

  task automatic t_block();
    apply(32'hE92D4010, '0);
    chk("R10", "block class", 64'(cls_o), 64'(oh(9)));
    chk("R10", "block order db", 64'(blk_order_o), 64'h2);
    chk("R10", "block user 0", 64'(blk_user_o), 64'h0);
    apply(32'hE8D00003, '0);
    chk("R10", "block order ia", 64'(blk_order_o), 64'h1);
    chk("R10", "block user 1", 64'(blk_user_o), 64'h1);
  endtask

  task automatic t_branch();
    apply(32'hEAFFFFFE, 32'h00001000);
    chk("R11", "branch class", 64'(cls_o), 64'(oh(10)));
    chk("R11", "branch back 8", 64'(br_target_o), 64'h00001000);
    chk("R11", "branch no link", 64'(br_link_o), 64'h0);
    apply(32'hEB000010, 32'h00002000);
    chk("R11", "branch fwd", 64'(br_target_o), 64'h00002048);
    chk("R11", "branch link", 64'(br_link_o), 64'h1);
    apply(32'hEA800000, 32'h00000100);
    chk("R11", "branch wrap", 64'(br_target_o), 64'hFE000108);
  endtask

  task automatic t_coproc();
    apply(32'hED9F0100, '0);
    chk("R12", "cp transfer", 64'(cls_o), 64'(oh(11)));
    apply(32'hEE000000, '0);
    chk("R12", "cp data", 64'(cls_o), 64'(oh(12)));
    apply(32'hEE100010, '0);
    chk("R12", "cp move", 64'(cls_o), 64'(oh(13)));
    chk("R12", "cp move read", 64'(cp_read_o), 64'h1);
    apply(32'hEE000010, '0);
    chk("R12", "cp move write", 64'(cp_read_o), 64'h0);
    apply(32'hEF000011, '0);
    chk("R12", "software interrupt", 64'(cls_o), 64'(oh(14)));
    chk("R1", "swi not undef", 64'(undef_o), 64'h0);
  endtask

  task automatic t_latency();
    apply(32'hEF000000, '0);
    @(negedge clk);
    instr_i = 32'hEA000000;
    #5;
    chk("R13", "old class held before edge", 64'(cls_o), 64'(oh(14)));
    @(negedge clk);
    chk("R13", "new class after edge", 64'(cls_o), 64'(oh(10)));
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R13", "sync reset clears", 64'(cls_o), 64'h0);
    rst = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_multiply();
    t_bx_swap();
    t_status();
    t_halfword();
    t_dataproc();
    t_shifts();
    t_single();
    t_block();
    t_branch();
    t_coproc();
    t_latency();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule